// File: doc/BRIEF.md
# Glitch-rejecting UART byte receiver

This block takes one asynchronous serial line from a host and recovers 8N1 bytes: a low start bit, eight data bits sent least significant bit first, and a high stop bit. The line first passes through a two-stage synchroniser. A high-to-low transition on the synchronised line starts a frame. Each data bit is sampled once at its centre, with timing counted from that edge. The bit period in clock cycles is set at elaboration from the clock frequency and baud rate parameters. The baud rate must match the sender.

Each framing bit is checked over a window of cycles, not at one sample. The start bit must stay low on every cycle from the edge to its centre. The stop bit must stay high on every cycle from its centre to three quarters of its length. A frame that fails either check is dropped without any report, so short noise pulses on the line cannot produce a byte. When a frame is accepted, the block updates the byte output and raises a valid strobe for one cycle.

Top module: `uart_glitch_rx`

## Requirements
- R1: `rx_line` reaches the receiver logic through two flip-flops. If a frame starts with `rx_line` going low just after a rising edge, `rx_valid` is high after exactly HALF + 9*BIT + QUART + 3 rising edges. Here BIT is the bit period, HALF = BIT/2 and QUART = BIT/4, using integer division. For BIT = 16 this is 159 edges.
- R2: BIT = CLK_HZ / BAUD, using integer division. Each data bit is sampled BIT cycles after the previous sample. The first data bit is sampled BIT cycles after the start-bit centre, which is HALF cycles after the edge.
- R3: Each accepted frame produces exactly one `rx_valid` pulse, and the pulse is one cycle wide.
- R4: After a falling edge, the synchronised line must read low on every one of the next HALF cycles. If it reads high in that time, the receiver returns to idle and no byte is produced.
  - With BIT = 16, a low pulse of 8 cycles is dropped.
  - A low pulse of 9 cycles followed by a high line is accepted as byte 0xFF.
- R5: The stop bit must read high on every cycle from its centre (offset BIT/2 into the bit) to offset BIT/2 + QUART. A low reading anywhere in that window drops the frame with no pulse. A stop bit that is low for its whole length is also dropped.
- R6: Low readings inside the stop bit before its centre or after the window end have no effect on acceptance.
- R7: Data bits are received least significant bit first: the first data bit on the line becomes `rx_byte[0]`.
- R8: After a frame is dropped, or while the line stays low, the receiver starts a new frame only on a fresh high-to-low transition.
- R9: Reset clears `rx_byte` to 0x00 and `rx_valid` to 0. `rx_byte` changes only together with a `rx_valid` pulse and otherwise holds the last accepted byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Asynchronous serial input, idles high |
| rx_byte | output | 8 | Last accepted byte |
| rx_valid | output | 1 | One-cycle strobe marking a newly accepted byte |

## Verification
The hardest cases to reach are frames whose data is clean but whose stop bit carries a two-cycle low pulse. Each such pulse lands at a chosen offset inside the stop bit.
- Pulses just before the centre and after three quarters must be ignored.
- A pulse that merely touches the centre or the window end must drop the frame.

The stimulus table places these pulses cycle-exactly, one bit-period offset at a time, because the bench drives the line on falling clock edges with a known two-cycle synchroniser lag. A pulse after the window also creates a spurious falling edge. This checks that the receiver falls back to idle before the next real frame.

// File: rtl/uart_glitch_rx.sv
module uart_glitch_rx #(
  parameter int CLK_HZ = 100_000_000,
  parameter int BAUD   = 115_200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_line,
  output logic [7:0] rx_byte,
  output logic       rx_valid
);
  localparam int BIT_CYC = CLK_HZ / BAUD;
  localparam int HALF    = BIT_CYC / 2;
  localparam int QUART   = BIT_CYC / 4;
  localparam int WIN_END = BIT_CYC + QUART;
  localparam int CW      = $clog2(WIN_END + 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rx_st_t;

  rx_st_t        st;
  logic          sync_a, line_s, line_q;
  logic [CW-1:0] cnt;
  logic [2:0]    idx;
  logic [7:0]    shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a <= 1'b1;
      line_s <= 1'b1;
      line_q <= 1'b1;
    end else begin
      sync_a <= rx_line;
      line_s <= sync_a;
      line_q <= line_s;
    end
  end

  wire fall = line_q & ~line_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cnt      <= '0;
      idx      <= '0;
      shreg    <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (st)
        S_IDLE:
          if (fall) begin
            st  <= S_START;
            cnt <= CW'(1);
          end
        S_START:
          if (line_s) st <= S_IDLE;
          else if (cnt == CW'(HALF)) begin
            st  <= S_DATA;
            cnt <= CW'(1);
            idx <= '0;
          end else cnt <= cnt + 1'b1;
        S_DATA:
          if (cnt == CW'(BIT_CYC)) begin
            shreg <= {line_s, shreg[7:1]};
            cnt   <= CW'(1);
            idx   <= idx + 1'b1;
            if (idx == 3'd7) st <= S_STOP;
          end else cnt <= cnt + 1'b1;
        S_STOP:
          if (!line_s && cnt >= CW'(BIT_CYC)) st <= S_IDLE;
          else if (cnt == CW'(WIN_END)) begin
            st       <= S_IDLE;
            rx_byte  <= shreg;
            rx_valid <= 1'b1;
          end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_glitch_rx_chk.sv
module uart_glitch_rx_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_line,
  input logic [7:0] rx_byte,
  input logic       rx_valid,
  input logic       line_s,
  input logic [1:0] st
);
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
  end

  a_r1_two_stage: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2) |-> (line_s == $past(rx_line, 2)));

  a_r3_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  a_r4_start_abort: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd1 && line_s) |=> (st == 2'd0));

  a_r5_stop_high: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(line_s));

  a_r9_byte_hold: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd1 && rx_byte != $past(rx_byte)) |-> rx_valid);
endmodule

bind uart_glitch_rx uart_glitch_rx_chk chk (
  .clk(clk), .rst(rst), .rx_line(rx_line), .rx_byte(rx_byte),
  .rx_valid(rx_valid), .line_s(line_s), .st(st)
);

// File: tb/uart_glitch_rx_test.sv
module uart_glitch_rx_test;
  localparam int CLK_HZ = 100_000_000;
  localparam int BAUD   = 6_250_000;
  localparam int BIT    = CLK_HZ / BAUD;
  localparam int HALF   = BIT / 2;
  localparam int QUART  = BIT / 4;
  localparam int LAT    = HALF + 9 * BIT + QUART + 3;
  localparam int NV     = 11;
  // {byte, stop-bit low-pulse offset (31 = none), accepted}
  localparam logic [13:0] VEC [NV] = '{
    {8'hA5, 5'd31, 1'b1}, {8'h00, 5'd31, 1'b1}, {8'hFF, 5'd31, 1'b1},
    {8'h3C, 5'd5,  1'b1}, {8'h81, 5'd6,  1'b1}, {8'h5A, 5'd7,  1'b0},
    {8'h96, 5'd9,  1'b0}, {8'hC3, 5'd11, 1'b0}, {8'h24, 5'd12, 1'b0},
    {8'h18, 5'd13, 1'b1}, {8'h01, 5'd31, 1'b1}
  };

  logic clk = 1'b0, rst = 1'b1, rx_line = 1'b1;
  logic [7:0] rx_byte;
  logic rx_valid;
  int nchk = 0, nfail = 0, cyc = 0, npulse = 0, nwide = 0, vcyc = 0;
  logic prev_v = 1'b0;

  always #5 clk = ~clk;

  uart_glitch_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) uut (
    .clk(clk), .rst(rst), .rx_line(rx_line), .rx_byte(rx_byte), .rx_valid(rx_valid)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (rx_valid) begin
      npulse = npulse + 1;
      vcyc = cyc;
      if (prev_v) nwide = nwide + 1;
    end
    prev_v = rx_valid;
  end

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input int goff, input bit stop_low, output int t0);
    @(negedge clk);
    rx_line = 1'b0;
    t0 = cyc;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_line = b[i];
      repeat (BIT) @(negedge clk);
    end
    for (int j = 0; j < BIT; j++) begin
      rx_line = !(stop_low || j == goff || j == goff + 1);
      @(negedge clk);
    end
    if (!stop_low) rx_line = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int t0, p0;
    logic [7:0] keep;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 reset byte", rx_byte, 8'h00);
    check("R9 reset valid", rx_valid, 0);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] b;
      int goff;
      bit ok;
      b = VEC[v][13:6];
      goff = VEC[v][5:1];
      ok = VEC[v][0];
      p0 = npulse;
      keep = rx_byte;
      send(b, goff, 1'b0, t0);
      // R5 R6: acceptance decided by stop-bit window
      check(ok ? "R6 R3 pulse count" : "R5 pulse count", npulse - p0, ok ? 1 : 0);
      if (ok) begin
        check("R2 R7 byte", rx_byte, b);
        check("R1 latency", vcyc - t0, LAT);
      end else check("R9 byte held", rx_byte, keep);
    end
    check("R3 pulse width", nwide, 0);

    // R4: start low for HALF cycles only
    p0 = npulse;
    keep = rx_byte;
    @(negedge clk) rx_line = 1'b0;
    repeat (HALF) @(negedge clk);
    rx_line = 1'b1;
    repeat (200) @(negedge clk);
    check("R4 short start dropped", npulse - p0, 0);
    check("R4 byte held", rx_byte, keep);

    // R4: start low for HALF+1 cycles reads as 0xFF
    p0 = npulse;
    @(negedge clk) rx_line = 1'b0;
    repeat (HALF + 1) @(negedge clk);
    rx_line = 1'b1;
    repeat (200) @(negedge clk);
    check("R4 boundary start pulses", npulse - p0, 1);
    check("R4 boundary start byte", rx_byte, 8'hFF);

    // R5 R8: stop bit fully low, line held low, then a fresh frame
    p0 = npulse;
    send(8'h42, 31, 1'b1, t0);
    repeat (60) @(negedge clk);
    check("R5 low stop dropped", npulse - p0, 0);
    check("R8 no restart while low", rx_byte, 8'hFF);
    rx_line = 1'b1;
    repeat (20) @(negedge clk);
    send(8'h77, 31, 1'b0, t0);
    check("R8 fresh frame pulses", npulse - p0, 1);
    check("R8 fresh frame byte", rx_byte, 8'h77);
    check("R1 latency after recovery", vcyc - t0, LAT);
    check("R3 pulse width final", nwide, 0);
    finish_run();
  end
endmodule